// File: doc/BRIEF.md
# Vector unpack format expander

This block turns a stream of packed input elements into a stream of four-lane vectors. Each lane is 32 bits wide and goes out one at a time with its lane index (0 = X, 1 = Y, 2 = Z, 3 = W), so a later write-mask stage can act on each lane. A command gives a 5-bit format code and a count of counted lanes. The block then pulls elements through a valid/ready input port and pushes lanes through a valid/ready output port. Scalar data is repeated across all four lanes. Two- and three-element formats fill their missing lanes with defined substitutes. A packed 5-5-5-1 colour word is spread over the four lanes by bit shifting.

A two-bit lane offset is kept between lanes, between stalls and between commands. A command whose count runs out mid-vector leaves the offset where it stopped, and the next command carries on from that lane. The control is a two-state machine. **ST_IDLE** accepts a command through transition **T_START** (`cmd_valid` high while idle). **ST_RUN** emits lanes and goes back to idle through transition **T_FINISH**. T_FINISH is taken when the next lane is a counted lane and the remaining count is zero.

Top module: `unpack_expander`

## Requirements
- R1: A command is taken only while `cmd_ready` is high (idle), and `cmd_ready` stays low until the command completes. The format code is: bits [4:3] shape (0 scalar, 1 two-element, 2 three-element, 3 four-element); bits [2:1] width (0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = 5-5-5-1 colour with the four-element shape, otherwise treated as 32-bit); bit [0] signed.
- R2: `out_lane` steps 0,1,2,3,0,… on each lane handshake. The offset is held during stalls and carried over from one command to the next.
- R3: In the scalar shape, one element is sent on every lane. It is consumed after lane 3, or earlier on the lane that brings the count to zero.
- R4: In the two-element shape, lanes 0 and 1 each consume one element and are counted. Lane 2 repeats the lane-0 value. Lane 3 is 0 for 32-bit width and repeats the lane-1 value for 8- and 16-bit widths. Lanes 2 and 3 consume nothing and are not counted.
- R5: In the three-element shape, lanes 0 to 2 consume and are counted. Lane 3 copies the element waiting at the input without consuming it and without counting it.
- R6: In the four-element shape with 8-, 16- or 32-bit width, every lane consumes one element and is counted.
- R7: In colour format, the lanes are built from one input word d. Lane 0 is d[4:0]<<3, lane 1 is d[9:5]<<3, lane 2 is d[14:10]<<3 and lane 3 is d[15]<<7. Upper input bits and the signed bit are ignored. The word is consumed after lane 3 or when the count reaches zero.
- R8: 8- and 16-bit elements are sign-extended to 32 bits when bit [0] is set, and zero-extended otherwise. Only the low 8 or 16 bits of `in_data` are used.
- R9: Each counted lane lowers the remaining count by one. The command ends, with `cmd_ready` high again, when the next lane is counted and the count is zero. A count of zero emits no lane and consumes nothing.
- R10: While `out_valid` is high and `out_ready` is low, the lane, its index and its data are held, and no input is consumed.
- R11: After reset the block is idle: `cmd_ready` is 1, `out_valid` and `in_ready` are 0, and the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_fmt | input | 5 | Format code, sampled at command start |
| cmd_count | input | CNT_W | Number of counted lanes for the command |
| in_valid | input | 1 | Packed element present |
| in_ready | output | 1 | Element consumed at this edge when valid |
| in_data | input | DATA_W | Packed element, right-aligned |
| out_valid | output | 1 | Lane present |
| out_ready | input | 1 | Downstream takes the lane |
| out_data | output | DATA_W | Expanded lane value |
| out_lane | output | 2 | Lane index 0..3 (X..W) |

## Verification
The hold-under-stall property assumes that the producer keeps `in_valid` and `in_data` steady until the element is consumed. This also covers the element that a three-element W lane only copies. The lane-stepping and colour checks assume that commands arrive only through the idle handshake. The stimulus changes an input element only after the edge at which it was taken. It removes a trailing element that was only copied once `cmd_ready` has returned high. Output stalls are made by toggling `out_ready` while the input is held steady.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

    parameter int FMT_W = 5;

    typedef enum logic [1:0] {
        SHP_S  = 2'd0,
        SHP_V2 = 2'd1,
        SHP_V3 = 2'd2,
        SHP_V4 = 2'd3
    } shape_e;

    typedef enum logic [1:0] {
        WID_32  = 2'd0,
        WID_16  = 2'd1,
        WID_8   = 2'd2,
        WID_RGB = 2'd3
    } width_e;

    typedef struct packed {
        shape_e shape;
        width_e width;
        logic   sgn;
    } fmt_t;

    typedef enum logic [1:0] {
        SRC_IN   = 2'd0,
        SRC_E0   = 2'd1,
        SRC_E1   = 2'd2,
        SRC_ZERO = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

endpackage

// File: rtl/unpack_lane_plan.sv
module unpack_lane_plan
    import unpack_pkg::*;
(
    input  fmt_t       fmt,
    input  logic [1:0] off,
    input  logic       last_cnt,
    output logic       counted,
    output logic       needs_in,
    output logic       pops,
    output src_e       src
);

    logic wrap_or_last;
    assign wrap_or_last = (off == 2'd3) || last_cnt;

    always_comb begin
        counted  = 1'b1;
        needs_in = 1'b1;
        pops     = 1'b1;
        src      = SRC_IN;
        unique case (fmt.shape)
            SHP_S: begin
                pops = wrap_or_last;
            end
            SHP_V2: begin
                if (off[1]) begin
                    counted  = 1'b0;
                    needs_in = 1'b0;
                    pops     = 1'b0;
                    if (!off[0])
                        src = SRC_E0;
                    else if (fmt.width == WID_8 || fmt.width == WID_16)
                        src = SRC_E1;
                    else
                        src = SRC_ZERO;
                end
            end
            SHP_V3: begin
                if (off == 2'd3) begin
                    counted = 1'b0;
                    pops    = 1'b0;
                end
            end
            SHP_V4: begin
                if (fmt.width == WID_RGB)
                    pops = wrap_or_last;
            end
        endcase
    end

endmodule

// File: rtl/unpack_extend.sv
module unpack_extend
    import unpack_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fmt_t              fmt,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] val
);

    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int FLD_W  = 5;
    localparam int FLD_SH = BYTE_W - FLD_W;

    logic signed [HALF_W-1:0] half_s;
    logic signed [BYTE_W-1:0] byte_s;
    logic [FLD_W-1:0]         fld;
    logic [DATA_W-1:0]        colour;

    assign half_s = raw[HALF_W-1:0];
    assign byte_s = raw[BYTE_W-1:0];

    always_comb begin
        unique case (off)
            2'd0: fld = raw[FLD_W-1:0];
            2'd1: fld = raw[2*FLD_W-1:FLD_W];
            2'd2: fld = raw[3*FLD_W-1:2*FLD_W];
            2'd3: fld = '0;
        endcase
        if (off == 2'd3)
            colour = DATA_W'({raw[HALF_W-1], {(BYTE_W-1){1'b0}}});
        else
            colour = DATA_W'({fld, {FLD_SH{1'b0}}});
    end

    always_comb begin
        unique case (fmt.width)
            WID_16:  val = fmt.sgn ? DATA_W'(half_s) : DATA_W'(raw[HALF_W-1:0]);
            WID_8:   val = fmt.sgn ? DATA_W'(byte_s) : DATA_W'(raw[BYTE_W-1:0]);
            WID_RGB: val = (fmt.shape == SHP_V4) ? colour : raw;
            WID_32:  val = raw;
        endcase
    end

endmodule

// File: rtl/unpack_seq.sv
module unpack_seq
    import unpack_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [FMT_W-1:0] cmd_fmt,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic             counted,
    input  logic             needs_in,
    input  logic             pops,
    output logic             cmd_ready,
    output fmt_t             fmt_q,
    output logic [1:0]       off_q,
    output logic             last_cnt,
    output logic             out_valid,
    output logic             in_ready,
    output logic             lane_fire
);

    state_e           st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             exhausted;
    logic             start;

    assign exhausted = counted && (cnt_q == '0);
    assign last_cnt  = (cnt_q == CNT_W'(1));
    assign start     = (st_q == ST_IDLE) && cmd_valid;
    assign lane_fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (cmd_valid) st_d = ST_RUN;  // T_START
            ST_RUN:  if (exhausted) st_d = ST_IDLE; // T_FINISH
        endcase
    end

    always_comb begin
        cmd_ready = 1'b0;
        out_valid = 1'b0;
        in_ready  = 1'b0;
        unique case (st_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_RUN: begin
                out_valid = !exhausted && (!needs_in || in_valid);
                in_ready  = !exhausted && pops && out_ready;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q <= fmt_t'('0);
            cnt_q <= '0;
            off_q <= 2'd0;
        end else if (start) begin
            fmt_q <= fmt_t'(cmd_fmt);
            cnt_q <= cmd_count;
        end else if (lane_fire) begin
            off_q <= off_q + 2'd1;
            if (counted) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/unpack_expander.sv
module unpack_expander
    import unpack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [4:0]        cmd_fmt,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_lane
);

    localparam int N_HELD = 2;

    fmt_t              fmt_q;
    logic [1:0]        off_q;
    logic              last_cnt, counted, needs_in, pops, lane_fire;
    src_e              src;
    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] held [N_HELD];

    unpack_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_fmt   (cmd_fmt),
        .cmd_count (cmd_count),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .counted   (counted),
        .needs_in  (needs_in),
        .pops      (pops),
        .cmd_ready (cmd_ready),
        .fmt_q     (fmt_q),
        .off_q     (off_q),
        .last_cnt  (last_cnt),
        .out_valid (out_valid),
        .in_ready  (in_ready),
        .lane_fire (lane_fire)
    );

    unpack_lane_plan u_plan (
        .fmt      (fmt_q),
        .off      (off_q),
        .last_cnt (last_cnt),
        .counted  (counted),
        .needs_in (needs_in),
        .pops     (pops),
        .src      (src)
    );

    unpack_extend #(.DATA_W(DATA_W)) u_ext (
        .fmt (fmt_q),
        .off (off_q),
        .raw (in_data),
        .val (ext_val)
    );

    for (genvar i = 0; i < N_HELD; i++) begin : g_held
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                held[i] <= '0;
            else if (lane_fire && src == SRC_IN && off_q == 2'(i))
                held[i] <= ext_val;
        end
    end

    always_comb begin
        unique case (src)
            SRC_IN:   out_data = ext_val;
            SRC_E0:   out_data = held[0];
            SRC_E1:   out_data = held[1];
            SRC_ZERO: out_data = '0;
        endcase
    end

    assign out_lane = off_q;

endmodule

// File: rtl/unpack_expander_chk.sv
module unpack_expander_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [4:0]        cmd_fmt,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        out_lane
);

    logic [1:0] prev_lane;
    logic [4:0] fmt_l;
    logic       fire;
    logic       is_colour;

    assign fire      = out_valid && out_ready;
    assign is_colour = (fmt_l[4:3] == 2'b11) && (fmt_l[2:1] == 2'b11);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lane <= 2'd3;
            fmt_l     <= '0;
        end else begin
            if (fire) prev_lane <= out_lane;
            if (cmd_valid && cmd_ready) fmt_l <= cmd_fmt;
        end
    end

    a_r2_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> out_lane == prev_lane + 2'd1);

    a_r1_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r10_hold_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_lane) && $stable(out_data));

    a_r10_pop_with_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> fire);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!out_valid && !in_ready));

    a_r7_colour_w: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_colour && out_lane == 2'd3) |->
            (out_data[DATA_W-1:8] == '0 && out_data[6:0] == '0));

endmodule

bind unpack_expander unpack_expander_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_fmt   (cmd_fmt),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_lane  (out_lane)
);

// File: tb/sim_unpack_expander.sv
module sim_unpack_expander;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [4:0]  cmd_fmt;
    logic [15:0] cmd_count;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic [1:0]  out_lane;

    always #5 clk = ~clk;

    unpack_expander u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_fmt   (cmd_fmt),
        .cmd_count (cmd_count),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_lane  (out_lane)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] stream   [8];
    logic [1:0]  got_lane [16];
    logic [31:0] got_data [16];
    int          n_got, n_used, stall_bad;
    bit          busy_seen;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_lane(input string tag, input int i, input logic [1:0] ln, input logic [31:0] d);
        chk($sformatf("%s lane idx %0d", tag, i), 32'(got_lane[i]), 32'(ln));
        chk($sformatf("%s data idx %0d", tag, i), got_data[i], d);
    endtask

    task automatic run_cmd(input logic [4:0] f, input logic [15:0] cnt, input int nin, input bit stall);
        int          cyc;
        bit          pend;
        logic [31:0] hd;
        logic [1:0]  hl;
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_fmt = f; cmd_count = cnt;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        n_got = 0; n_used = 0; stall_bad = 0; busy_seen = 0; pend = 0; cyc = 0;
        while (cyc < 300) begin
            in_valid  = (n_used < nin);
            in_data   = (n_used < nin) ? stream[n_used] : 32'h0;
            out_ready = stall ? (cyc % 2 == 1) : 1'b1;
            @(negedge clk);
            if (pend) begin
                if (!out_valid || out_data !== hd || out_lane !== hl) stall_bad++;
                pend = 0;
            end
            if (cmd_ready) break;
            busy_seen = 1;
            if (out_valid && out_ready) begin
                got_lane[n_got] = out_lane;
                got_data[n_got] = out_data;
                n_got++;
            end
            if (out_valid && !out_ready) begin
                pend = 1; hd = out_data; hl = out_lane;
            end
            if (in_valid && in_ready) n_used++;
            @(posedge clk); #1;
            cyc++;
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 cmd_ready after reset", 32'(cmd_ready), 32'd1);
        chk("R11 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R11 in_ready after reset", 32'(in_ready), 32'd0);
    endtask

    task automatic t_v4_32;
        stream[0] = 32'h1111_1111; stream[1] = 32'h2222_2222;
        stream[2] = 32'h3333_3333; stream[3] = 32'h4444_4444;
        run_cmd(5'b11000, 16'd4, 4, 0);
        chk("R1 busy while running", 32'(busy_seen), 32'd1);
        chk("R6 lane count", n_got, 4);
        chk("R6 consumed", n_used, 4);
        for (int i = 0; i < 4; i++) chk_lane("R6 R2 v4_32", i, 2'(i), stream[i]);
    endtask

    task automatic t_scalar_s8;
        stream[0] = 32'h0000_00F0;
        run_cmd(5'b00101, 16'd4, 1, 0);
        chk("R3 lane count", n_got, 4);
        chk("R3 consumed", n_used, 1);
        for (int i = 0; i < 4; i++) chk_lane("R3 R8 scalar s8", i, 2'(i), 32'hFFFF_FFF0);
    endtask

    task automatic t_scalar_u16_split;
        stream[0] = 32'h1234_8001; stream[1] = 32'h0000_00AB;
        run_cmd(5'b00010, 16'd6, 2, 0);
        chk("R9 lane count", n_got, 6);
        chk("R3 consumed early at zero count", n_used, 2);
        for (int i = 0; i < 4; i++) chk_lane("R3 R8 scalar u16", i, 2'(i), 32'h0000_8001);
        chk_lane("R9 scalar tail", 4, 2'd0, 32'h0000_00AB);
        chk_lane("R9 scalar tail", 5, 2'd1, 32'h0000_00AB);
    endtask

    task automatic t_v4_s16_resume;
        stream[0] = 32'h0000_8000; stream[1] = 32'h0000_7FFF;
        run_cmd(5'b11011, 16'd2, 2, 0);
        chk("R2 lane count", n_got, 2);
        chk_lane("R2 R8 resume offset", 0, 2'd2, 32'hFFFF_8000);
        chk_lane("R2 R8 resume offset", 1, 2'd3, 32'h0000_7FFF);
    endtask

    task automatic t_v2_32;
        stream[0] = 32'hAAAA_0001; stream[1] = 32'hBBBB_0002;
        run_cmd(5'b01000, 16'd2, 2, 0);
        chk("R4 lane count", n_got, 4);
        chk("R4 consumed", n_used, 2);
        chk_lane("R4 v2_32", 0, 2'd0, 32'hAAAA_0001);
        chk_lane("R4 v2_32", 1, 2'd1, 32'hBBBB_0002);
        chk_lane("R4 v2_32 fill", 2, 2'd2, 32'hAAAA_0001);
        chk_lane("R4 v2_32 fill", 3, 2'd3, 32'h0000_0000);
    endtask

    task automatic t_v2_small;
        stream[0] = 32'h0000_01F5; stream[1] = 32'h0000_02C3;
        run_cmd(5'b01100, 16'd2, 2, 0);
        chk("R4 u8 consumed", n_used, 2);
        chk_lane("R4 R8 v2_u8", 0, 2'd0, 32'h0000_00F5);
        chk_lane("R4 R8 v2_u8", 1, 2'd1, 32'h0000_00C3);
        chk_lane("R4 v2_u8 fill", 2, 2'd2, 32'h0000_00F5);
        chk_lane("R4 v2_u8 fill", 3, 2'd3, 32'h0000_00C3);
        stream[0] = 32'h0000_FFFF; stream[1] = 32'h0000_0001;
        run_cmd(5'b01011, 16'd2, 2, 0);
        chk_lane("R4 R8 v2_s16 fill", 2, 2'd2, 32'hFFFF_FFFF);
        chk_lane("R4 R8 v2_s16 fill", 3, 2'd3, 32'h0000_0001);
    endtask

    task automatic t_v3_peek;
        stream[0] = 32'd1; stream[1] = 32'd2; stream[2] = 32'd3; stream[3] = 32'd4;
        run_cmd(5'b10000, 16'd3, 4, 0);
        chk("R5 lane count", n_got, 4);
        chk("R5 W not consumed", n_used, 3);
        for (int i = 0; i < 4; i++) chk_lane("R5 v3_32", i, 2'(i), 32'(i + 1));
    endtask

    task automatic t_colour;
        stream[0] = 32'hFFFF_ABCD;
        run_cmd(5'b11111, 16'd4, 1, 0);
        chk("R7 lane count", n_got, 4);
        chk("R7 consumed", n_used, 1);
        chk_lane("R7 colour", 0, 2'd0, 32'h0000_0068);
        chk_lane("R7 colour", 1, 2'd1, 32'h0000_00F0);
        chk_lane("R7 colour", 2, 2'd2, 32'h0000_0050);
        chk_lane("R7 colour", 3, 2'd3, 32'h0000_0080);
    endtask

    task automatic t_stall;
        stream[0] = 32'hDEAD_0000; stream[1] = 32'hDEAD_0001;
        stream[2] = 32'hDEAD_0002; stream[3] = 32'hDEAD_0003;
        run_cmd(5'b11000, 16'd4, 4, 1);
        chk("R10 held under stall", stall_bad, 0);
        chk("R10 consumed", n_used, 4);
        chk("R10 lane count", n_got, 4);
        for (int i = 0; i < 4; i++) chk_lane("R10 stalled v4", i, 2'(i), stream[i]);
    endtask

    task automatic t_zero_count;
        stream[0] = 32'h5555_5555;
        run_cmd(5'b11000, 16'd0, 1, 0);
        chk("R9 zero count lanes", n_got, 0);
        chk("R9 zero count consumed", n_used, 0);
    endtask

    task automatic t_v3_short;
        stream[0] = 32'd5; stream[1] = 32'd6; stream[2] = 32'd9;
        run_cmd(5'b10000, 16'd2, 3, 0);
        chk("R9 v3 stops before Z", n_got, 2);
        chk("R9 v3 consumed", n_used, 2);
        chk_lane("R9 v3 short", 1, 2'd1, 32'd6);
        stream[0] = 32'd7;
        run_cmd(5'b00000, 16'd2, 1, 0);
        chk("R3 scalar from lane 2 count", n_got, 2);
        chk("R3 scalar wrap consumed", n_used, 1);
        chk_lane("R2 R3 scalar resume", 0, 2'd2, 32'd7);
        chk_lane("R2 R3 scalar resume", 1, 2'd3, 32'd7);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_fmt = '0; cmd_count = '0;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_v4_32();
        t_scalar_s8();
        t_scalar_u16_split();
        t_v4_s16_resume();
        t_v2_32();
        t_v2_small();
        t_v3_peek();
        t_colour();
        t_stall();
        t_zero_count();
        t_v3_short();
        finish_run();
    end

endmodule